// File: doc/BRIEF.md
# Double-Buffered Converter Input Register

This block is the digital front end of a 16-bit converter. A word is assembled in a first-rank holding register, then moved into a second-rank register whose contents are the converter code. The first rank can be filled in two ways. In serial mode it takes one bit for each chip-select rising edge, in either bit order. In byte mode it takes a byte from an 8-bit port into the upper half, the lower half or both halves.

Moving the word into the second rank is level-controlled by a load input. A clear input forces the second rank to a zero code and leaves the first rank as it was. The low-byte enable picks which zero code is used. This lets the held word be restored afterwards by asserting load again. In serial mode the bit shifted out of the first rank appears on a chain output, so that several devices can be daisy-chained. Chip select, clear and load are synchronized into the system clock with two flops. The data port, mode and enables must be stable around each strobe.

Top module: `dac_dual_rank_if`

## Requirements
- R1: After synchronous reset, `code_out` is 0x0000, `chain_out` is 0 and the first rank holds 0x0000.
- R2: With `byte_mode` low and `data_in[1]` low (MSB first), each chip-select rising edge shifts the first rank left by one and puts `data_in[0]` into bit 0.
- R3: With `byte_mode` low and `data_in[1]` high (LSB first), each chip-select rising edge shifts the first rank right by one and puts `data_in[0]` into bit 15.
- R4: On each serial strobe, `chain_out` takes the bit that leaves the first rank: old bit 15 when MSB first, old bit 0 when LSB first. It holds that value until the next serial strobe. Byte writes leave it unchanged.
- R5: With `byte_mode` high, a chip-select rising edge writes `data_in` into bits 15:8 if `hi_en` is high and into bits 7:0 if `lo_en` is high. The two halves can be written in either order. With both enables high, both halves get the same byte.
- R6: In serial mode, `hi_en` and `lo_en` have no effect on how the first rank is loaded.
- R7: Chip select is edge-sensitive. Holding it high for many cycles performs exactly one write.
- R8: While `load_dac` is high and `clear` is low, `code_out` follows the first rank. While both are low, `code_out` holds its value.
- R9: While `clear` is high, `code_out` becomes 0x0000 if `lo_en` is low and 0x8000 if `lo_en` is high. The first rank is unchanged, so a later load restores the earlier word.
- R10: When `clear` and `load_dac` are high together, clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_mode | input | 1 | 0 = serial loading, 1 = byte loading |
| data_in | input | 8 | Byte port. In serial mode bit 0 is serial data and bit 1 selects bit order |
| cs_strobe | input | 1 | Chip select. Its rising edge performs one write |
| hi_en | input | 1 | Upper-half enable (byte mode) |
| lo_en | input | 1 | Lower-half enable (byte mode). Also selects the clear code |
| load_dac | input | 1 | Level-sensitive transfer of first rank to second rank |
| clear | input | 1 | Level-sensitive clear of the second rank |
| code_out | output | 16 | Second-rank converter code |
| chain_out | output | 1 | Bit shifted out by the last serial strobe |

## Verification
Clear and load can both be active in the same synchronized cycle. The bench raises both inputs on the same clock edge, so they pass through the synchronizer together, and then expects the selected zero code rather than the held word. It then drops clear while load stays high and expects the first-rank word to come back, which shows that clear did not touch the first rank. Random sequences of serial strobes, byte strobes, loads and clears are checked against a bench model of both ranks.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int SYNC_STAGES = 2;

    typedef logic [WORD_W-1:0] code_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        LOAD_SERIAL = 1'b0,
        LOAD_BYTE   = 1'b1
    } load_mode_e;

    typedef enum logic {
        ORDER_MSB = 1'b0,
        ORDER_LSB = 1'b1
    } bit_order_e;

    typedef struct packed {
        logic       strobe;
        load_mode_e mode;
        bit_order_e order;
        logic       sin;
        logic       hi_sel;
        logic       lo_sel;
        byte_t      data;
    } wr_req_t;

    function automatic code_t zero_code(input logic bipolar);
        code_t z;
        z = '0;
        z[WORD_W-1] = bipolar;
        return z;
    endfunction
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[i] <= '0;
            else     stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/dacif_edge.sv
module dacif_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic pulse
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    assign pulse = level & ~prev_q;

    // R7: a held chip select yields a single-cycle pulse
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);
endmodule

// File: rtl/dacif_rank1.sv
module dacif_rank1
    import dacif_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t req,
    output code_t   word_q,
    output logic    chain_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            chain_q <= 1'b0;
        end else if (req.strobe) begin
            if (req.mode == LOAD_SERIAL) begin
                if (req.order == ORDER_MSB) begin
                    word_q  <= {word_q[WORD_W-2:0], req.sin};
                    chain_q <= word_q[WORD_W-1];
                end else begin
                    word_q  <= {req.sin, word_q[WORD_W-1:1]};
                    chain_q <= word_q[0];
                end
            end else begin
                if (req.hi_sel) word_q[WORD_W-1:BYTE_W] <= req.data;
                if (req.lo_sel) word_q[BYTE_W-1:0]      <= req.data;
            end
        end
    end

    assert_hold_no_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        !req.strobe |=> $stable(word_q) && $stable(chain_q));

    assert_msb_shift_R2: assert property (@(posedge clk) disable iff (rst)
        req.strobe && req.mode == LOAD_SERIAL && req.order == ORDER_MSB
        |=> word_q[0] == $past(req.sin) && chain_q == $past(word_q[WORD_W-1]));

    assert_lsb_shift_R3: assert property (@(posedge clk) disable iff (rst)
        req.strobe && req.mode == LOAD_SERIAL && req.order == ORDER_LSB
        |=> word_q[WORD_W-1] == $past(req.sin) && chain_q == $past(word_q[0]));

    assert_byte_chain_R4: assert property (@(posedge clk) disable iff (rst)
        req.strobe && req.mode == LOAD_BYTE |=> $stable(chain_q));

    assert_low_kept_R5: assert property (@(posedge clk) disable iff (rst)
        req.strobe && req.mode == LOAD_BYTE && !req.lo_sel
        |=> $stable(word_q[BYTE_W-1:0]));
endmodule

// File: rtl/dacif_rank2.sv
module dacif_rank2
    import dacif_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  bipolar,
    input  logic  load,
    input  code_t d,
    output code_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (clr)  q <= zero_code(bipolar);
        else if (load) q <= d;
    end

    assert_clear_code_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == ($past(bipolar) ? 16'h8000 : 16'h0000)));

    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
        clr && load && (d != 16'h0000) && (d != 16'h8000) |=> q != $past(d));

    assert_follow_R8: assert property (@(posedge clk) disable iff (rst)
        load && !clr |=> q == $past(d));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !load && !clr |=> $stable(q));
endmodule

// File: rtl/dac_dual_rank_if.sv
module dac_dual_rank_if
    import dacif_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        byte_mode,
    input  logic [7:0]  data_in,
    input  logic        cs_strobe,
    input  logic        hi_en,
    input  logic        lo_en,
    input  logic        load_dac,
    input  logic        clear,
    output logic [15:0] code_out,
    output logic        chain_out
);
    logic [2:0] ctl_sync;
    logic       cs_pulse;
    wr_req_t    req;
    code_t      rank1_word;

    dacif_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_strobe, clear, load_dac}),
        .q   (ctl_sync)
    );

    dacif_edge u_cs_edge (
        .clk   (clk),
        .rst   (rst),
        .level (ctl_sync[2]),
        .pulse (cs_pulse)
    );

    always_comb begin
        req.strobe = cs_pulse;
        req.mode   = load_mode_e'(byte_mode);
        req.order  = bit_order_e'(data_in[1]);
        req.sin    = data_in[0];
        req.hi_sel = hi_en;
        req.lo_sel = lo_en;
        req.data   = data_in;
    end

    dacif_rank1 u_rank1 (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .word_q  (rank1_word),
        .chain_q (chain_out)
    );

    dacif_rank2 u_rank2 (
        .clk     (clk),
        .rst     (rst),
        .clr     (ctl_sync[1]),
        .bipolar (lo_en),
        .load    (ctl_sync[0]),
        .d       (rank1_word),
        .q       (code_out)
    );

    // R6: in serial mode the enables do not steer the load
    assert_serial_ignores_en_R6: assert property (@(posedge clk) disable iff (rst)
        cs_pulse && !byte_mode && !data_in[1]
        |=> rank1_word[15:1] == $past(rank1_word[14:0]));
endmodule

// File: tb/dac_dual_rank_if_test.sv
module dac_dual_rank_if_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        byte_mode, cs_strobe, hi_en, lo_en, load_dac, clear;
    logic [7:0]  data_in;
    logic [15:0] code_out;
    logic        chain_out;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_r1, m_r2;
    logic        m_chain;

    always #2.5 clk = ~clk;

    dac_dual_rank_if uut (
        .clk(clk), .rst(rst), .byte_mode(byte_mode), .data_in(data_in),
        .cs_strobe(cs_strobe), .hi_en(hi_en), .lo_en(lo_en),
        .load_dac(load_dac), .clear(clear),
        .code_out(code_out), .chain_out(chain_out)
    );

    function automatic logic [16:0] f_shift(input logic [15:0] w, input logic b,
                                             input logic lsb_first);
        if (lsb_first) return {w[0], b, w[15:1]};
        return {w[15], w[14:0], b};
    endfunction

    function automatic logic [15:0] f_byte(input logic [15:0] w, input logic [7:0] d,
                                           input logic hi, input logic lo);
        logic [15:0] r;
        r = w;
        if (hi) r[15:8] = d;
        if (lo) r[7:0] = d;
        return r;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic serial_bit(input logic b, input logic lsb_first, input logic he,
                              input logic le, input int hold);
        logic [16:0] r;
        byte_mode = 1'b0; data_in = {$urandom()} & 8'hFC;
        data_in[0] = b; data_in[1] = lsb_first; hi_en = he; lo_en = le;
        cycles(1); cs_strobe = 1'b1; cycles(hold); cs_strobe = 1'b0; cycles(4);
        r = f_shift(m_r1, b, lsb_first);
        m_chain = r[16]; m_r1 = r[15:0];
        check(lsb_first ? "R4 chain lsb" : "R4 chain msb", {15'b0, chain_out}, {15'b0, m_chain});
    endtask

    task automatic byte_wr(input logic [7:0] d, input logic he, input logic le);
        byte_mode = 1'b1; data_in = d; hi_en = he; lo_en = le;
        cycles(1); cs_strobe = 1'b1; cycles(4); cs_strobe = 1'b0; cycles(4);
        m_r1 = f_byte(m_r1, d, he, le);
        check("R4 byte keeps chain", {15'b0, chain_out}, {15'b0, m_chain});
    endtask

    task automatic do_load(input string req);
        load_dac = 1'b1; cycles(5); load_dac = 1'b0; cycles(4);
        m_r2 = m_r1;
        check(req, code_out, m_r2);
    endtask

    task automatic do_clear(input logic pol);
        lo_en = pol; clear = 1'b1; cycles(5); clear = 1'b0; cycles(4);
        m_r2 = pol ? 16'h8000 : 16'h0000;
        check("R9 clear code", code_out, m_r2);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; byte_mode = 1'b0; data_in = '0; cs_strobe = 1'b0;
        hi_en = 1'b0; lo_en = 1'b0; load_dac = 1'b0; clear = 1'b0;
        m_r1 = '0; m_r2 = '0; m_chain = 1'b0;
        cycles(4); rst = 1'b0; cycles(2);
        check("R1 reset code", code_out, 16'h0000);
        check("R1 reset chain", {15'b0, chain_out}, 16'h0000);
        do_load("R1 reset first rank");

        // R2 MSB-first word
        for (int i = 15; i >= 0; i--) serial_bit(((16'hA5C3 >> i) & 1) != 0, 1'b0, 1'b1, 1'b1, 4);
        do_load("R2 msb-first word");
        // R3 LSB-first word; shifted-out bits follow R4
        for (int i = 0; i < 16; i++) serial_bit(((16'h3C96 >> i) & 1) != 0, 1'b1, 1'b0, 1'b0, 4);
        do_load("R3 lsb-first word");
        // R6 enables toggled in serial mode
        for (int i = 0; i < 4; i++) serial_bit(i[0], 1'b0, i[1], ~i[0], 4);
        do_load("R6 enables ignored in serial");
        // R7 long chip-select pulse: exactly one shift
        serial_bit(1'b1, 1'b0, 1'b0, 1'b0, 20);
        do_load("R7 single write per edge");
        // R5 halves in both orders and both at once
        byte_wr(8'h12, 1'b0, 1'b1); byte_wr(8'hAB, 1'b1, 1'b0);
        do_load("R5 low then high");
        byte_wr(8'h77, 1'b1, 1'b0); byte_wr(8'h0E, 1'b0, 1'b1);
        do_load("R5 high then low");
        byte_wr(8'h5D, 1'b1, 1'b1);
        do_load("R5 both halves");
        // R8 hold while load low
        byte_wr(8'hF0, 1'b1, 1'b0);
        check("R8 hold without load", code_out, m_r2);
        // R9 clear both polarities, first rank survives
        do_clear(1'b1);
        do_clear(1'b0);
        do_load("R9 load restores after clear");
        // R10 clear and load together
        lo_en = 1'b1; clear = 1'b1; load_dac = 1'b1; cycles(6);
        check("R10 clear wins over load", code_out, 16'h8000);
        clear = 1'b0; cycles(5);
        check("R10 load resumes after clear", code_out, m_r1);
        load_dac = 1'b0; m_r2 = m_r1; cycles(3);

        // constrained random mix
        for (int n = 0; n < 300; n++) begin
            case ($urandom() % 5)
                0, 1: serial_bit($urandom() % 2 == 1, $urandom() % 2 == 1,
                                 $urandom() % 2 == 1, $urandom() % 2 == 1, 2 + $urandom() % 4);
                2:    byte_wr(8'($urandom()), $urandom() % 2 == 1, $urandom() % 2 == 1);
                3:    do_load("R8 random load");
                default: do_clear($urandom() % 2 == 1);
            endcase
        end
        do_load("R8 final load");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule